// File: doc/BRIEF.md
# PWM Pin Polarity and Ownership Stage

This block sits between a PWM waveform generator and the device pads for a set of complementary output pairs, four by default. Every pair has a high-side and a low-side pin. For each pin the block decides who owns the pad: the PWM path or the general-purpose I/O path. When the PWM path owns a pin, the block drives the pad actively. It applies one polarity setting shared by all high-side pins and a second setting shared by all low-side pins. When the PWM path does not own a pin, the pad value and output-enable come straight from the GPIO data and direction inputs.

Ownership is held in a per-pin enable register. Software may load this register with a write strobe. Its value after reset comes from a static configuration bit. With that bit at 0, all pins come out of reset owned by PWM, and each pin sits at the inactive level its polarity defines. This lets a board leave out external pull resistors. With the bit at 1, all pins come out of reset released to GPIO.

The pin path is combinational from the PWM, GPIO and polarity inputs. Only the enable register is clocked. The polarity and reset-behaviour bits are treated as static. They are not required to change glitch-free while the block runs. The block has no data stream, so every port is a plain control or data pin with no handshake.

Top module: `pwm_pin_ctrl`

## Requirements
- R1: All high-side pins (pin index 2k, pair k) that the PWM path owns drive the raw high-side PWM value when the high polarity bit is 1, and its inverse when that bit is 0.
- R2: All low-side pins (pin index 2k+1, pair k) that the PWM path owns drive the raw low-side PWM value when the low polarity bit is 1, and its inverse when that bit is 0. The setting is independent of the high polarity bit.
- R3: A pin whose enable bit is 1 has output-enable 1. Its GPIO data and direction inputs have no effect on its pad value or output-enable.
- R4: A pin whose enable bit is 0 has its pad value equal to its GPIO data bit and its output-enable equal to its GPIO direction bit (1 means drive).
- R5: With the reset-behaviour bit at 1, reset clears every enable bit, so all pins follow their GPIO inputs.
- R6: With the reset-behaviour bit at 0, reset sets every enable bit. With all PWM inputs at 0, each pin then drives its inactive level: 0 for polarity 1 and 1 for polarity 0.
- R7: When the write strobe is high at a rising clock edge, the enable register takes the write data from that edge on. Without the strobe, the register holds its value.
- R8: Enable bit and pin index 2k belong to the high side of pair k, and index 2k+1 belongs to the low side of pair k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the enable register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hi_pol | input | 1 | High-side polarity, 1 = active-high |
| cfg_lo_pol | input | 1 | Low-side polarity, 1 = active-high |
| cfg_rst_release | input | 1 | Reset behaviour: 1 = release pins to GPIO, 0 = PWM owns pins |
| pwm_hi | input | NPAIRS | Raw active-high PWM signal per high side |
| pwm_lo | input | NPAIRS | Raw active-high PWM signal per low side |
| gpio_dat | input | 2*NPAIRS | GPIO output data per pin |
| gpio_dir | input | 2*NPAIRS | GPIO output-enable per pin |
| own_wr | input | 1 | Write strobe for the enable register |
| own_wdata | input | 2*NPAIRS | New enable bits |
| pad_val | output | 2*NPAIRS | Pad output value |
| pad_oe | output | 2*NPAIRS | Pad output-enable |

## Verification
On every cycle the assertions check the following. The pin mux gives PWM-owned pins an active drive and passes GPIO pins through untouched. Each side's drive matches its raw input under its own polarity bit. The register holds its reset value for the whole of reset and takes written data on the next edge. Only the bench's scenarios can show the rest. These include the sweep over every enable mask under all four polarity combinations and both reset behaviours, with GPIO patterns varied to show they are ignored. They also include the mapping of bits to pair and side, and the inactive levels seen right after reset.

// File: rtl/pwm_pin_pkg.sv
package pwm_pin_pkg;

  typedef enum logic {
    SIDE_HI = 1'b0,
    SIDE_LO = 1'b1
  } side_e;

  // Side served by a flat pin index: even = high, odd = low.
  function automatic side_e side_of(input int unsigned idx);
    return (idx % 2 == 0) ? SIDE_HI : SIDE_LO;
  endfunction

  // Pair served by a flat pin index.
  function automatic int unsigned pair_of(input int unsigned idx);
    return idx / 2;
  endfunction

  // Level on the pad for a raw active-high value under a polarity setting.
  function automatic logic apply_pol(input logic raw, input logic active_high);
    return active_high ? raw : ~raw;
  endfunction

  // Level with the PWM signal deasserted.
  function automatic logic idle_level(input logic active_high);
    return ~active_high;
  endfunction

endpackage

// File: rtl/pwm_own_reg.sv
module pwm_own_reg #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_release,
  input  logic             wr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] own_q
);

  localparam logic [NPINS-1:0] ALL_OWNED = {NPINS{1'b1}};
  localparam logic [NPINS-1:0] ALL_FREE  = '0;

  logic [NPINS-1:0] rst_val;
  assign rst_val = rst_release ? ALL_FREE : ALL_OWNED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= rst_val;
    end else if (wr) begin
      own_q <= wdata;
    end
  end

  // R5 / R6: the register holds its configured reset value during reset.
  a_r5_r6_reset_value: assert property (@(posedge clk)
    !rst_n |-> (own_q == (rst_release ? ALL_FREE : ALL_OWNED)))
    else $error("enable register not at reset value");

  // R7: a write lands on the next edge.
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (own_q == $past(wdata)))
    else $error("enable write lost");

  // R7: without a write the register holds.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(own_q))
    else $error("enable register changed without write");

endmodule

// File: rtl/pwm_pol_stage.sv
module pwm_pol_stage
  import pwm_pin_pkg::*;
#(
  parameter int unsigned NPAIRS = 4,
  localparam int unsigned NPINS = 2 * NPAIRS
) (
  input  logic              hi_pol,
  input  logic              lo_pol,
  input  logic [NPAIRS-1:0] raw_hi,
  input  logic [NPAIRS-1:0] raw_lo,
  output logic [NPINS-1:0]  drive
);

  // Interleave each pair onto the flat pin order: 2k high, 2k+1 low (R8).
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    if (side_of(p) == SIDE_HI) begin : g_hi
      assign drive[p] = apply_pol(raw_hi[pair_of(p)], hi_pol);
    end else begin : g_lo
      assign drive[p] = apply_pol(raw_lo[pair_of(p)], lo_pol);
    end
  end

endmodule

// File: rtl/pwm_pin_mux.sv
module pwm_pin_mux #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] own,
  input  logic [NPINS-1:0] pwm_drive,
  input  logic [NPINS-1:0] gp_dat,
  input  logic [NPINS-1:0] gp_dir,
  output logic [NPINS-1:0] pad_val,
  output logic [NPINS-1:0] pad_oe
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_comb begin
      if (own[p]) begin
        pad_val[p] = pwm_drive[p];
        pad_oe[p]  = 1'b1;
      end else begin
        pad_val[p] = gp_dat[p];
        pad_oe[p]  = gp_dir[p];
      end
    end

    // R3: an owned pin is always driven from the PWM path.
    a_r3_owned_drives: assert property (@(posedge clk) disable iff (!rst_n)
      own[p] |-> (pad_oe[p] && pad_val[p] == pwm_drive[p]))
      else $error("owned pin not driven by PWM");

    // R4: a released pin mirrors its GPIO inputs.
    a_r4_released_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !own[p] |-> (pad_oe[p] == gp_dir[p] && pad_val[p] == gp_dat[p]))
      else $error("released pin not following GPIO");
  end

endmodule

// File: rtl/pwm_pin_ctrl.sv
module pwm_pin_ctrl
  import pwm_pin_pkg::*;
#(
  parameter int unsigned NPAIRS = 4,
  localparam int unsigned NPINS = 2 * NPAIRS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hi_pol,
  input  logic              cfg_lo_pol,
  input  logic              cfg_rst_release,
  input  logic [NPAIRS-1:0] pwm_hi,
  input  logic [NPAIRS-1:0] pwm_lo,
  input  logic [NPINS-1:0]  gpio_dat,
  input  logic [NPINS-1:0]  gpio_dir,
  input  logic              own_wr,
  input  logic [NPINS-1:0]  own_wdata,
  output logic [NPINS-1:0]  pad_val,
  output logic [NPINS-1:0]  pad_oe
);

  logic [NPINS-1:0] own_q;
  logic [NPINS-1:0] drive;

  pwm_own_reg #(.NPINS(NPINS)) u_own (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_release (cfg_rst_release),
    .wr          (own_wr),
    .wdata       (own_wdata),
    .own_q       (own_q)
  );

  pwm_pol_stage #(.NPAIRS(NPAIRS)) u_pol (
    .hi_pol (cfg_hi_pol),
    .lo_pol (cfg_lo_pol),
    .raw_hi (pwm_hi),
    .raw_lo (pwm_lo),
    .drive  (drive)
  );

  pwm_pin_mux #(.NPINS(NPINS)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .own       (own_q),
    .pwm_drive (drive),
    .gp_dat    (gpio_dat),
    .gp_dir    (gpio_dir),
    .pad_val   (pad_val),
    .pad_oe    (pad_oe)
  );

  // Pad-level checks per pair: the pad agrees with the raw input under the side's polarity.
  for (genvar k = 0; k < NPAIRS; k++) begin : g_chk
    // R1: high side of pair k.
    a_r1_hi_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      own_q[2*k] |-> (pad_val[2*k] == (cfg_hi_pol ? pwm_hi[k] : !pwm_hi[k])))
      else $error("high-side polarity wrong");

    // R2: low side of pair k.
    a_r2_lo_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      own_q[2*k+1] |-> (pad_val[2*k+1] == (cfg_lo_pol ? pwm_lo[k] : !pwm_lo[k])))
      else $error("low-side polarity wrong");

    // R6: with PWM idle an owned pin rests at the idle level of its side.
    a_r6_idle_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[2*k] && !pwm_hi[k]) |-> (pad_val[2*k] == idle_level(cfg_hi_pol)))
      else $error("high-side idle level wrong");
  end

endmodule

// File: tb/pwm_pin_ctrl_test.sv
module pwm_pin_ctrl_test;

  localparam int NPAIRS = 4;
  localparam int NPINS  = 2 * NPAIRS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              cfg_hi_pol = 1'b1, cfg_lo_pol = 1'b1, cfg_rst_release = 1'b0;
  logic [NPAIRS-1:0] pwm_hi = '0, pwm_lo = '0;
  logic [NPINS-1:0]  gpio_dat = '0, gpio_dir = '0;
  logic              own_wr = 1'b0;
  logic [NPINS-1:0]  own_wdata = '0;
  logic [NPINS-1:0]  pad_val, pad_oe;

  int total = 0;
  int bad   = 0;
  logic [NPINS-1:0] mdl_own;   // bench's own view of the enable bits

  always #10 clk = ~clk;

  pwm_pin_ctrl #(.NPAIRS(NPAIRS)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hi_pol(cfg_hi_pol), .cfg_lo_pol(cfg_lo_pol), .cfg_rst_release(cfg_rst_release),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .gpio_dat(gpio_dat), .gpio_dir(gpio_dir),
    .own_wr(own_wr), .own_wdata(own_wdata),
    .pad_val(pad_val), .pad_oe(pad_oe)
  );

  // Compare every pin against the arithmetic model (R8 index mapping).
  task automatic check_pins(input string ctx);
    for (int i = 0; i < NPINS; i++) begin
      logic side, raw, pol, ev, eo;
      string rq;
      side = i[0];
      raw  = side ? pwm_lo[i/2] : pwm_hi[i/2];
      pol  = side ? cfg_lo_pol : cfg_hi_pol;
      if (mdl_own[i]) begin
        ev = raw ^ ~pol;
        eo = 1'b1;
        rq = side ? "R2/R3" : "R1/R3";
      end else begin
        ev = gpio_dat[i];
        eo = gpio_dir[i];
        rq = "R4";
      end
      total++;
      if (pad_val[i] !== ev || pad_oe[i] !== eo) begin
        bad++;
        $display("FAIL %s %s pin%0d: val=%b oe=%b expected val=%b oe=%b",
                 rq, ctx, i, pad_val[i], pad_oe[i], ev, eo);
      end
    end
  endtask

  task automatic do_reset(input logic rel, input logic hp, input logic lp);
    @(negedge clk);
    cfg_rst_release = rel; cfg_hi_pol = hp; cfg_lo_pol = lp;
    pwm_hi = '0; pwm_lo = '0;
    gpio_dat = 8'hA5; gpio_dir = 8'h3C;
    rst_n = 1'b0;
    @(negedge clk);
    mdl_own = rel ? '0 : '1;
    // R5 / R6: reset state, idle levels for owned pins.
    check_pins(rel ? "R5 reset release" : "R6 reset owned");
    rst_n = 1'b1;
    @(negedge clk);
    check_pins(rel ? "R5 after reset" : "R6 after reset");
  endtask

  task automatic write_own(input logic [NPINS-1:0] m);
    @(negedge clk);
    own_wr = 1'b1; own_wdata = m;
    @(negedge clk);
    own_wr = 1'b0;
    mdl_own = m;   // R7: visible after the edge
  endtask

  initial begin
    #(20 * 190000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mdl_own = '0;
    #2 rst_n = 1'b0;
    for (int rel = 0; rel < 2; rel++) begin
      for (int pc = 0; pc < 4; pc++) begin
        do_reset(rel[0], pc[0], pc[1]);
        // Sweep every enable mask (R3, R4, R8) with varied PWM and GPIO patterns (R1, R2).
        for (int m = 0; m < (1 << NPINS); m++) begin
          write_own(m[NPINS-1:0]);
          for (int v = 0; v < 6; v++) begin
            pwm_hi   = NPAIRS'(v * 5 + m);
            pwm_lo   = NPAIRS'(~(v * 3) ^ (m >> 2));
            gpio_dat = NPINS'(m * 37 + v * 91);
            gpio_dir = NPINS'(~(m * 11) + v * 53);
            #2;
            check_pins("sweep");
          end
        end
        // R7: without the strobe, new write data is ignored.
        @(negedge clk);
        own_wdata = ~mdl_own;
        @(negedge clk);
        @(negedge clk);
        check_pins("R7 hold without strobe");
        // R7: a strobe in a single cycle takes effect.
        write_own(8'h96);
        check_pins("R7 single write");
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule